// File: doc/BRIEF.md
# Compare-Based Timer Channel

This block is one timer channel for one core. It watches a 64-bit system count that runs freely and is shared by all channels. It raises a level interrupt once its own count reaches a programmed compare value. The channel's count is the shared count minus a 64-bit offset. With the parameter `VIRTUAL` set to 1 the offset can be written, so the channel can act as a virtual timer. With `VIRTUAL` set to 0 the offset is fixed at zero and the channel acts as a physical timer.

Software sets the deadline in one of two ways. It can write an absolute 64-bit compare value. It can also write a signed 32-bit down-count, which is turned into an absolute compare value relative to the current count. A small control word holds the enable bit, the mask bit and a read-only status bit.

Registers are accessed through a write-enable, a 3-bit select and a 64-bit data bus. Read data is combinational from the select.

Top module: `arch_timer_chan`

## Requirements
- R1: The register select chooses a register as follows: 0 is control, 1 is compare, 2 is down-count, 3 is offset and 4 is the channel count. The control word reads back as follows:
  - bit 0 is the enable bit, and writes set it from wdata bit 0;
  - bit 1 is the mask bit, and writes set it from wdata bit 1;
  - bit 2 is the status bit, and writes to it are ignored;
  - bits 63:3 read as zero.
- R2: The channel count (select 4) equals `sys_cnt_i` minus the offset register, modulo 2^64. The offset register (select 3) reads back the last value written to it.
- R3: The compare register (select 1) reads back the last absolute value written to it. The condition is met when the channel count is greater than or equal to the compare value, both taken as unsigned numbers. The status bit equals enable AND condition.
- R4: A read of the down-count (select 2) returns (compare minus channel count), truncated to 32 bits and zero-extended to 64 bits.
- R5: A write to the down-count sets the compare value to the channel count of the write cycle plus wdata[31:0], sign-extended to 64 bits.
- R6: `irq_o` equals enable AND status AND NOT mask. It is a level that follows the count and the registers with no extra delay.
- R7: While `rst_ni` is low, enable, mask, compare and offset are all zero. As a result, `irq_o` is 0 and the control word reads 0.
- R8: A write takes effect at the rising clock edge that samples it. From then on, the status bit, `irq_o` and the read data reflect the new value.
- R9: With `VIRTUAL`=0 the offset reads as zero and writes to it are ignored, so the channel count equals `sys_cnt_i`.
- R10: A select value of 5, 6 or 7 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_cnt_i | input | 64 | Shared free-running system count |
| we_i | input | 1 | Register write enable |
| sel_i | input | 3 | Register select |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench places the count exactly at the compare value, one below it and one above it. A design that compares strictly, or that compares signed values, would then fire one tick late or would fire at once when the compare value sits in the upper half of the range.

Down-count writes use negative values and zero. Sign-extending them wrongly would put the deadline about 2^32 ticks away instead of in the past. Writing the offset causes wrap-around, which a design that saturates the subtraction would miss.

The bench also sets the status bit in writes and uses the unused select codes. A design that stored the status bit, or that decoded only part of the select, would show a wrong control read-back or a corrupted register.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_CMP  = 3'd1;
  localparam logic [2:0] SEL_DOWN = 3'd2;
  localparam logic [2:0] SEL_OFF  = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
  localparam int CTL_USED = 3;
endpackage

// File: rtl/timer_count.sv
module timer_count #(
  parameter int CNT_W   = 64,
  parameter bit VIRTUAL = 1'b1
) (
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic [CNT_W-1:0] off_i,
  output logic [CNT_W-1:0] cnt_o
);
  if (VIRTUAL) begin : g_virt
    assign cnt_o = sys_cnt_i - off_i;
  end else begin : g_phys
    logic [CNT_W-1:0] unused_off;
    assign unused_off = off_i;
    assign cnt_o = sys_cnt_i;
  end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int TV_W    = 32,
  parameter bit VIRTUAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             en_o,
  output logic             mask_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] off_o
);
  localparam int EXT_W = CNT_W - TV_W;

  logic [CNT_W-1:0] down_sext;
  assign down_sext = {{EXT_W{wdata_i[TV_W-1]}}, wdata_i[TV_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= 1'b0;
      cmp_o  <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_CTRL: begin
          en_o   <= wdata_i[CTL_EN];
          mask_o <= wdata_i[CTL_MASK];
        end
        SEL_CMP:  cmp_o <= wdata_i;
        SEL_DOWN: cmp_o <= cnt_i + down_sext;
        default: ;
      endcase
    end
  end

  if (VIRTUAL) begin : g_off
    logic [CNT_W-1:0] off_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        off_q <= '0;
      else if (we_i && sel_i == SEL_OFF)  off_q <= wdata_i;
    end
    assign off_o = off_q;
  end else begin : g_no_off
    assign off_o = '0;
  end
endmodule

// File: rtl/timer_cmp.sv
module timer_cmp #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             en_i,
  input  logic             mask_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             stat_o,
  output logic             irq_o,
  output logic [TV_W-1:0]  down_o
);
  logic [CNT_W-1:0] diff;
  logic             met;

  assign met    = cnt_i >= cmp_i;
  assign stat_o = en_i & met;
  assign irq_o  = stat_o & ~mask_i;
  assign diff   = cmp_i - cnt_i;
  assign down_o = diff[TV_W-1:0];

  logic [CNT_W-TV_W-1:0] unused_hi;
  assign unused_hi = diff[CNT_W-1:TV_W];
endmodule

// File: rtl/arch_timer_chan.sv
module arch_timer_chan
  import timer_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int TV_W    = 32,
  parameter bit VIRTUAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int CTL_PAD = CNT_W - CTL_USED;
  localparam int TV_PAD  = CNT_W - TV_W;

  logic             ctl_en, ctl_mask, ctl_stat;
  logic [CNT_W-1:0] cmp_q, off_q, chan_cnt;
  logic [TV_W-1:0]  down_val;

  timer_count #(.CNT_W(CNT_W), .VIRTUAL(VIRTUAL)) u_count (
    .sys_cnt_i(sys_cnt_i), .off_i(off_q), .cnt_o(chan_cnt)
  );

  timer_regs #(.CNT_W(CNT_W), .TV_W(TV_W), .VIRTUAL(VIRTUAL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .cnt_i(chan_cnt), .en_o(ctl_en), .mask_o(ctl_mask),
    .cmp_o(cmp_q), .off_o(off_q)
  );

  timer_cmp #(.CNT_W(CNT_W), .TV_W(TV_W)) u_cmp (
    .en_i(ctl_en), .mask_i(ctl_mask), .cmp_i(cmp_q), .cnt_i(chan_cnt),
    .stat_o(ctl_stat), .irq_o(irq_o), .down_o(down_val)
  );

  always_comb begin
    case (sel_i)
      SEL_CTRL: rdata_o = {{CTL_PAD{1'b0}}, ctl_stat, ctl_mask, ctl_en};
      SEL_CMP:  rdata_o = cmp_q;
      SEL_DOWN: rdata_o = {{TV_PAD{1'b0}}, down_val};
      SEL_OFF:  rdata_o = off_q;
      SEL_CNT:  rdata_o = chan_cnt;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/arch_timer_chan_chk.sv
module arch_timer_chan_chk
  import timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] sys_cnt_i,
  input logic             we_i,
  input logic [2:0]       sel_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic             ctl_en,
  input logic [CNT_W-1:0] cmp_q
);
  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_en);

  p_ctrl_pad_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_CTRL) |-> (rdata_o[CNT_W-1:CTL_USED] == '0));

  p_ctrl_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CTRL) |=> (ctl_en == $past(wdata_i[CTL_EN])));

  p_cmp_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CMP) |=> (cmp_q == $past(wdata_i)));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> (irq_o || sys_cnt_i != $past(sys_cnt_i)));

  p_unused_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > SEL_CNT) |-> (rdata_o == '0));
endmodule

bind arch_timer_chan arch_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_cnt_i(sys_cnt_i), .we_i(we_i),
  .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .ctl_en(ctl_en), .cmp_q(cmp_q)
);

// File: tb/sim_arch_timer_chan.sv
`timescale 1ns/1ps
module sim_arch_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, rdata_p;
  logic        irq, irq_p;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arch_timer_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(sys_cnt), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  arch_timer_chan #(.VIRTUAL(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(sys_cnt), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata_p), .irq_o(irq_p)
  );

  // reference state
  logic        m_en = 0, m_mask = 0;
  logic [63:0] m_cmp = 0, m_off = 0;

  function automatic logic [63:0] m_cnt(input logic [63:0] s);
    return s - m_off;
  endfunction

  function automatic logic m_stat(input logic [63:0] s);
    return m_en && (m_cnt(s) >= m_cmp);
  endfunction

  function automatic logic [63:0] m_rd(input logic [2:0] sl, input logic [63:0] s);
    logic [63:0] d;
    case (sl)
      3'd0: return {61'd0, m_stat(s), m_mask, m_en};
      3'd1: return m_cmp;
      3'd2: begin d = m_cmp - m_cnt(s); return {32'd0, d[31:0]}; end
      3'd3: return m_off;
      3'd4: return m_cnt(s);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] sl);
    case (sl)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one vector: drive at negedge, compare after settling, model updates at edge
  task automatic step(input bit w, input logic [2:0] sl, input logic [63:0] d,
                      input logic [63:0] s, input string tag);
    logic [63:0] e;
    @(negedge clk);
    we = w; sel = sl; wdata = d; sys_cnt = s;
    #1;
    e = m_rd(sl, s);
    check(rdata === e, (tag == "") ? tag_of(sl) : tag, rdata, e);
    check(irq === (m_stat(s) && !m_mask), "R6", {63'd0, irq},
          {63'd0, m_stat(s) && !m_mask});
    if (sl == 3'd3 || sl == 3'd4)
      check(rdata_p === ((sl == 3'd3) ? 64'd0 : s), "R9", rdata_p,
            (sl == 3'd3) ? 64'd0 : s);
    @(posedge clk);
    if (w) begin
      case (sl)
        3'd0: begin m_en = d[0]; m_mask = d[1]; end
        3'd1: m_cmp = d;
        3'd2: m_cmp = m_cnt(s) + {{32{d[31]}}, d[31:0]};
        3'd3: m_off = d;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    logic [63:0] lf;
    logic [63:0] s;
    // reset state (R7)
    sys_cnt = 64'd50;
    sel = 3'd0;
    #3;
    check(rdata === 64'd0 && irq === 1'b0, "R7", {rdata[62:0], irq}, 64'd0);
    sel = 3'd1; #1;
    check(rdata === 64'd0, "R7", rdata, 64'd0);
    sel = 3'd3; #1;
    check(rdata === 64'd0, "R7", rdata, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // compare boundaries
    step(1, 3'd1, 64'd100, 64'd10, "R3");
    step(1, 3'd0, 64'h7, 64'd99, "R1");      // status bit in write ignored
    step(0, 3'd0, 64'd0, 64'd99, "R1");
    step(0, 3'd0, 64'd0, 64'd100, "R3");
    step(0, 3'd0, 64'd0, 64'd101, "R3");
    step(0, 3'd2, 64'd0, 64'd101, "R4");
    step(1, 3'd0, 64'h2, 64'd101, "R6");     // masked
    step(0, 3'd0, 64'd0, 64'd101, "R8");
    step(1, 3'd0, 64'h1, 64'd101, "R8");
    step(0, 3'd0, 64'd0, 64'd101, "R6");
    // upper-half compare value: unsigned compare
    step(1, 3'd1, 64'h8000_0000_0000_0000, 64'd200, "R3");
    step(0, 3'd0, 64'd0, 64'd200, "R3");
    step(0, 3'd0, 64'd0, 64'h8000_0000_0000_0000, "R3");
    // down-count writes
    step(1, 3'd2, 64'h0000_0000_FFFF_FFF0, 64'd1000, "R5");
    step(0, 3'd1, 64'd0, 64'd1000, "R5");
    step(0, 3'd0, 64'd0, 64'd1000, "R5");
    step(1, 3'd2, 64'd0, 64'd2000, "R5");
    step(0, 3'd1, 64'd0, 64'd2000, "R5");
    step(1, 3'd2, 64'h0000_0000_0000_0020, 64'd2000, "R5");
    step(0, 3'd2, 64'd0, 64'd2010, "R4");
    step(0, 3'd2, 64'd0, 64'd2040, "R4");
    // offset wrap
    step(1, 3'd3, 64'd5000, 64'd2040, "R2");
    step(0, 3'd4, 64'd0, 64'd2041, "R2");
    step(0, 3'd0, 64'd0, 64'd2041, "R3");
    // unused selects
    step(1, 3'd5, 64'hFFFF, 64'd2041, "R10");
    step(1, 3'd7, 64'hFFFF, 64'd2041, "R10");
    step(0, 3'd0, 64'd0, 64'd2041, "R10");
    step(0, 3'd1, 64'd0, 64'd2041, "R10");
    step(0, 3'd3, 64'd0, 64'd2041, "R10");

    // pseudo-random sweep
    lf = 64'h1234_5678_9ABC_DEF1;
    s  = 64'd3000;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      s = s + {61'd0, lf[2:0]};
      if (lf[7:5] == 3'd0)
        step(1, lf[10:8], (lf[11] ? s + {56'd0, lf[19:12]} - 64'd128
                                  : {32'd0, lf[43:12]}), s, "");
      else
        step(0, lf[10:8], 64'd0, s, "");
    end
    finish_run();
  end
endmodule